// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits beside a program counter and runs hardware loops with no branch instruction inside the loop body. A repeat command names an iteration count and either a single instruction or a block of instructions. The single instruction, or the first instruction of the block, is the one at the address after the command. The controller compares the fetch PC with the loop's last address every cycle. It either sends the PC back to the body start or lets it run on. Each extra iteration therefore costs no cycles. The only overhead is one flushed fetch slot when the loop is set up.

The PC logic loads `pc_target_o` whenever `pc_load_o` is high and otherwise increments. A fetch slot marked by `flush_o` is discarded. While a loop is active, interrupt requests are held pending and are released in the first cycle after the loop ends. A repeat command that arrives while a loop is running is ignored and raises a one-cycle error pulse.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, `loop_active_o`, `pc_load_o`, `flush_o`, `irq_inhibit_o`, `irq_take_o` and `rpt_err_o` are all low.
- R2: A repeat command accepted while idle in cycle T causes `flush_o` and `pc_load_o` to be high in cycle T+1, for that one cycle only. In that cycle `pc_target_o` is the command's fetch PC plus one. That slot is the only flushed slot of the loop.
- R3: In block mode (`rpt_block_i`=1), a count of N fetches every address from command PC+1 to `rpt_end_i` inclusive exactly N+1 times. The loop stays active for exactly 1+(N+1)*L cycles, where L is the body length.
- R4: In single mode (`rpt_block_i`=0), the instruction at command PC+1 is fetched N+1 times back to back. `rpt_end_i` is ignored.
- R5: When the fetch PC equals the loop's last address and the remaining count is nonzero, `pc_load_o` is high in that same cycle with the body start as target, `flush_o` is low, and the count decrements. This happens exactly N times per loop.
- R6: When the fetch PC equals the last address and the remaining count is zero, no load is requested. `loop_active_o` falls in the next cycle and the fetch PC continues at the last address plus one.
- R7: `irq_inhibit_o` is high while a loop is active, and `irq_take_o` stays low then. A request seen during the loop is held and appears on `irq_take_o` in the first cycle after `loop_active_o` falls, for one cycle.
- R8: With no loop active, `irq_req_i` appears on `irq_take_o` in the same cycle.
- R9: A repeat command while a loop is active is rejected. `rpt_err_o` is high in the next cycle for one cycle, and the running loop's executions are unchanged.
- R10: Count 127 gives 128 executions in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_start_i | input | 1 | Repeat command valid, issued with the command's fetch PC |
| rpt_count_i | input | CW (8) | Iteration count N (N+1 executions) |
| rpt_end_i | input | AW (16) | Last body address in block mode |
| rpt_block_i | input | 1 | 1 = block mode, 0 = single instruction |
| fetch_pc_i | input | AW (16) | Current fetch PC |
| irq_req_i | input | 1 | Interrupt request |
| pc_load_o | output | 1 | Override next PC |
| pc_target_o | output | AW (16) | Next PC when `pc_load_o` is high |
| flush_o | output | 1 | Discard the current fetch slot |
| loop_active_o | output | 1 | Loop in progress |
| irq_inhibit_o | output | 1 | Interrupts held back |
| irq_take_o | output | 1 | Interrupt released to the core |
| rpt_err_o | output | 1 | Rejected repeat command (one-cycle pulse) |

## Verification
The assertions assume that the PC follows `pc_load_o`/`pc_target_o` and otherwise increments by one. They also assume that in block mode the last address is not below the body start, so the fetch PC reaches it. The bench keeps to this with a one-line PC model and with block lengths of one or more. Repeat commands are issued at whatever address the free-running PC has reached. Rejected commands and interrupt requests are driven only while a loop has enough iterations left to still be active.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic {
    RPT_SINGLE = 1'b0,
    RPT_BLOCK  = 1'b1
  } rpt_mode_e;

  localparam int unsigned SETUP_FLUSH_SLOTS = 1;
endpackage

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  zol_pkg::rpt_mode_e mode_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] cmd_pc_i,
  input  logic          loop_back_i,
  input  logic          loop_exit_i,
  output logic          active_o,
  output logic          setup_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] last_o,
  output logic [CW-1:0] rem_o
);
  import zol_pkg::*;

  function automatic logic [CW-1:0] dec_count(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic [AW-1:0] body_start(input logic [AW-1:0] pc);
    return pc + 1'b1;
  endfunction

  logic          active_q, setup_q;
  logic [AW-1:0] start_q, last_q;
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      setup_q  <= 1'b0;
      start_q  <= '0;
      last_q   <= '0;
      rem_q    <= '0;
    end else if (accept_i) begin
      active_q <= 1'b1;
      setup_q  <= 1'b1;
      start_q  <= body_start(cmd_pc_i);
      last_q   <= (mode_i == RPT_BLOCK) ? end_i : body_start(cmd_pc_i);
      rem_q    <= count_i;
    end else begin
      setup_q <= 1'b0;
      if (loop_back_i) rem_q <= dec_count(rem_q);
      if (loop_exit_i) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign setup_o  = setup_q;
  assign start_o  = start_q;
  assign last_o   = last_q;
  assign rem_o    = rem_q;

  a_r5_count_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back_i |=> rem_q == dec_count($past(rem_q)));
  a_r6_exit_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit_i |=> !active_q);
  a_r2_setup_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    setup_q |=> !setup_q);
  a_r9_start_kept_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> (!active_q || $stable(start_q)));
endmodule

// File: rtl/zol_cmp.sv
module zol_cmp #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          active_i,
  input  logic          setup_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] last_i,
  input  logic [CW-1:0] rem_i,
  output logic          loop_back_o,
  output logic          loop_exit_o,
  output logic          load_o,
  output logic [AW-1:0] target_o,
  output logic          flush_o
);
  logic at_last;

  always_comb begin
    at_last     = active_i && !setup_i && (fetch_pc_i == last_i);
    loop_back_o = at_last && (rem_i != '0);
    loop_exit_o = at_last && (rem_i == '0);
    load_o      = setup_i || loop_back_o;
    target_o    = start_i;
    flush_o     = setup_i;
  end
endmodule

// File: rtl/zol_irq.sv
module zol_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic inhibit_i,
  output logic take_o,
  output logic pend_o
);
  logic pend_q;

  assign take_o = (req_i || pend_q) && !inhibit_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (take_o)             pend_q <= 1'b0;
    else if (req_i && inhibit_i) pend_q <= 1'b1;
  end

  a_r7_release_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(inhibit_i) && $past(pend_q)) |-> take_o);
  a_r7_held_request_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && inhibit_i) |=> (pend_q || take_o));
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rpt_start_i,
  input  logic [CW-1:0] rpt_count_i,
  input  logic [AW-1:0] rpt_end_i,
  input  logic          rpt_block_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          irq_req_i,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_target_o,
  output logic          flush_o,
  output logic          loop_active_o,
  output logic          irq_inhibit_o,
  output logic          irq_take_o,
  output logic          rpt_err_o
);
  import zol_pkg::*;

  logic          active, setup, loop_back, loop_exit, accept, reject;
  logic [AW-1:0] start_addr, last_addr;
  logic [CW-1:0] remaining;
  logic          irq_pend, err_q;
  rpt_mode_e     mode;

  assign mode   = rpt_block_i ? RPT_BLOCK : RPT_SINGLE;
  assign accept = rpt_start_i && !active;
  assign reject = rpt_start_i && active;

  zol_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .mode_i(mode),
    .count_i(rpt_count_i), .end_i(rpt_end_i), .cmd_pc_i(fetch_pc_i),
    .loop_back_i(loop_back), .loop_exit_i(loop_exit),
    .active_o(active), .setup_o(setup), .start_o(start_addr),
    .last_o(last_addr), .rem_o(remaining)
  );

  zol_cmp #(.AW(AW), .CW(CW)) u_cmp (
    .active_i(active), .setup_i(setup), .fetch_pc_i(fetch_pc_i),
    .start_i(start_addr), .last_i(last_addr), .rem_i(remaining),
    .loop_back_o(loop_back), .loop_exit_o(loop_exit),
    .load_o(pc_load_o), .target_o(pc_target_o), .flush_o(flush_o)
  );

  zol_irq u_irq (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .inhibit_i(active),
    .take_o(irq_take_o), .pend_o(irq_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject;
  end

  assign rpt_err_o     = err_q;
  assign loop_active_o = active;
  assign irq_inhibit_o = active;

  a_r2_flush_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (flush_o && pc_load_o && pc_target_o == $past(fetch_pc_i) + 1'b1));
  a_r2_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  a_r9_reject_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (rpt_err_o && loop_active_o));
  a_r5_backedge_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !flush_o) |-> (loop_active_o && pc_target_o <= fetch_pc_i));
  a_r7_no_take_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> !(irq_take_o && irq_inhibit_o));
endmodule

// File: tb/zol_ctrl_tb.sv
module zol_ctrl_tb;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rpt_start = 1'b0, rpt_block = 1'b0, irq_req = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic [AW-1:0] rpt_end = '0;
  logic [AW-1:0] pc;
  logic pc_load, flush, active, inhibit, take, err;
  logic [AW-1:0] target;

  always #4 clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rpt_start_i(rpt_start), .rpt_count_i(rpt_count),
    .rpt_end_i(rpt_end), .rpt_block_i(rpt_block), .fetch_pc_i(pc),
    .irq_req_i(irq_req), .pc_load_o(pc_load), .pc_target_o(target),
    .flush_o(flush), .loop_active_o(active), .irq_inhibit_o(inhibit),
    .irq_take_o(take), .rpt_err_o(err)
  );

  // simple PC model
  always_ff @(posedge clk) begin
    if (!rst_n)       pc <= '0;
    else if (pc_load) pc <= target;
    else              pc <= pc + 1'b1;
  end

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    int    execs;
    int    act_cycles;
    int    backs;
  } exp_t;
  exp_t sb[$];

  int bs, be;
  int n_act = 0, n_flush = 0, n_exec = 0, n_back = 0;
  bit prev_act = 1'b0;

  // monitor: counts loop activity and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (active) begin
        n_act++;
        if (flush) n_flush++;
        else begin
          if (int'(pc) >= bs && int'(pc) <= be) n_exec++;
          if (pc_load) n_back++;
        end
      end
      if (prev_act && !active) begin
        if (sb.size() == 0) check(1'b0, "scoreboard empty", 0, 1);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(n_exec == e.execs, {e.tag, " executions"}, n_exec, e.execs);
          check(n_act == e.act_cycles, {e.tag, " active cycles"}, n_act, e.act_cycles);
          check(n_back == e.backs, "R5 loop-backs", n_back, e.backs);
          check(n_flush == 1, "R2 single flush", n_flush, 1);
        end
        n_act = 0; n_flush = 0; n_exec = 0; n_back = 0;
      end
      prev_act = active;
    end
  end

  task automatic run_loop(input string tag, input bit blk, input int cnt, input int len,
                          input bit irq_mid, input bit err_mid);
    int r;
    exp_t e;
    @(posedge clk); #1;
    r  = int'(pc);
    bs = r + 1;
    be = blk ? r + len : r + 1;
    e.tag = tag; e.execs = (cnt + 1) * (be - bs + 1);
    e.act_cycles = 1 + e.execs; e.backs = cnt;
    sb.push_back(e);
    rpt_start = 1'b1; rpt_count = CW'(cnt); rpt_block = blk;
    rpt_end   = blk ? AW'(r + len) : 16'hBEEF;  // R4: ignored in single mode
    @(posedge clk); #1;
    rpt_start = 1'b0;
    check(flush && pc_load, "R2 flush after start", int'(flush), 1);
    check(int'(target) == bs, "R2 target", int'(target), bs);
    if (err_mid) begin
      repeat (2) @(posedge clk);
      #1; rpt_start = 1'b1; rpt_count = 8'd50; rpt_end = AW'(r + 40); rpt_block = 1'b1;
      @(posedge clk); #1;
      rpt_start = 1'b0;
      check(err == 1'b1, "R9 error pulse", int'(err), 1);
      @(posedge clk); #1;
      check(err == 1'b0, "R9 error clears", int'(err), 0);
    end
    if (irq_mid) begin
      irq_req = 1'b1;
      check(take == 1'b0 && inhibit == 1'b1, "R7 held while active", int'(take), 0);
      @(posedge clk); #1;
      irq_req = 1'b0;
      check(take == 1'b0, "R7 still held", int'(take), 0);
    end
    do begin @(posedge clk); #1; end while (active);
    check(int'(pc) == be + 1, "R6 falls through", int'(pc), be + 1);
    if (irq_mid) begin
      check(take == 1'b1, "R7 released on exit", int'(take), 1);
      @(posedge clk); #1;
      check(take == 1'b0, "R7 single release", int'(take), 0);
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!active && !pc_load && !flush, "R1 loop idle", int'(active), 0);
    check(!inhibit && !take && !err, "R1 irq/err idle", int'(take), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    run_loop("R3", 1'b1, 0, 3, 1'b0, 1'b0);
    run_loop("R3", 1'b1, 1, 3, 1'b0, 1'b0);
    run_loop("R10", 1'b1, 127, 2, 1'b0, 1'b0);
    run_loop("R3", 1'b1, 2, 1, 1'b0, 1'b0);
    run_loop("R4", 1'b0, 0, 0, 1'b0, 1'b0);
    run_loop("R4", 1'b0, 1, 0, 1'b0, 1'b0);
    run_loop("R10", 1'b0, 127, 0, 1'b0, 1'b0);
    run_loop("R9", 1'b1, 3, 4, 1'b0, 1'b1);
    run_loop("R7", 1'b1, 4, 3, 1'b1, 1'b0);
    @(posedge clk); #1;
    irq_req = 1'b1; #1;
    check(take == 1'b1 && inhibit == 1'b0, "R8 idle irq passes", int'(take), 1);
    @(posedge clk); #1;
    irq_req = 1'b0; #1;
    check(take == 1'b0, "R8 idle irq drops", int'(take), 0);
    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule